// File: doc/BRIEF.md
# UART Modem Line Control and Status

This block handles the modem lines of one serial channel. A host writes a modem control register. That register drives the active-low request-to-send and data-terminal-ready pins. One bit of it drives an inverted user output pin and also sets the output enable of the shared interrupt pin. The four active-low modem inputs (clear-to-send, data-set-ready, ring indicator, carrier detect) pass through a synchroniser. Their levels appear in a status byte, and their changes set sticky flags in that byte. While enabled, any set flag raises a modem-status interrupt request. A host read of the status byte clears the flags.

A loopback control bit turns the channel back on itself. The transmit serial stream feeds the receiver, and the external receive pin is ignored. The transmit pin rests at the marking level. The control outputs are looped onto the status levels, and their external pins are held inactive. A reset input, active high, clears the control register and the flags. While reset is high it also holds the transmit pin and the receiver input at logic 1.

Top module: `modem_ctl_top`

## Requirements
- R1: With control bit 3 set and loopback off, `usr_n` is 0 and `irq_oe` is 1. With bit 3 clear, `usr_n` is 1 and `irq_oe` is 0. Both follow the write on the next clock edge.
- R2: While `rst` is high, `txd` and `rx_ser` are 1. After reset, `rts_n`, `dtr_n` and `usr_n` are 1, `irq_oe` is 0 and the four change flags (status bits 3:0) are 0.
- R3: Control bit 1 set (loopback off) drives `rts_n` low, and control bit 0 does the same for `dtr_n`. When cleared, each pin returns high.
- R4: `flow_hold` is 1 only while `auto_rts_en` is 1 and control bit 1 is 0. With `auto_rts_en` at 0, the request-to-send bit has no effect on `flow_hold`.
- R5: Status bits 4, 5 and 7 show the asserted (inverted) levels of clear-to-send, data-set-ready and carrier detect. Any change of one of these levels sets its flag in bit 0, 1 or 3 respectively, within SYNC_STAGES+1 clocks.
- R6: Status bit 6 shows the asserted ring level. Flag bit 2 is set only when `ri_n` goes from low to high. A high-to-low change leaves it clear.
- R7: A cycle with `msr_rd` high clears all change flags. A change detected in that same cycle still sets its flag.
- R8: `msi_req` is 1 exactly when `msi_en` is 1 and at least one change flag is set.
- R9: With control bit 4 (loopback) set, `txd` is 1 and `rx_ser` equals `tx_ser`, whatever `rxd` is. With loopback off, `txd` follows `tx_ser` and `rx_ser` follows `rxd`.
- R10: In loopback, the status levels come from control bits: clear-to-send from bit 1, data-set-ready from bit 0, ring from bit 2 and carrier from bit 3. The modem input pins are ignored, and `rts_n`, `dtr_n` and `usr_n` are held at 1. The same flag rules apply to these levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mcr_we | input | 1 | Write strobe for the control register |
| mcr_wdata | input | DATA_W | Control write data (bits 4:0 used) |
| msr_rd | input | 1 | Status read strobe, clears the change flags |
| msr_q | output | 8 | Status byte: levels in 7:4, flags in 3:0 |
| msi_en | input | 1 | Modem-status interrupt enable |
| auto_rts_en | input | 1 | Lets request-to-send gate receive flow |
| cts_n | input | 1 | Clear-to-send input, active low |
| dsr_n | input | 1 | Data-set-ready input, active low |
| ri_n | input | 1 | Ring indicator input, active low |
| dcd_n | input | 1 | Carrier detect input, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| usr_n | output | 1 | User output pin (inverse of control bit 3) |
| irq_oe | output | 1 | Output enable for the shared interrupt pin |
| msi_req | output | 1 | Modem-status interrupt request |
| flow_hold | output | 1 | Asks the receive path to hold off the far end |
| tx_ser | input | 1 | Serial stream from the transmitter |
| txd | output | 1 | Transmit data pin |
| rxd | input | 1 | Receive data pin |
| rx_ser | output | 1 | Serial stream to the receiver |

## Verification
Each random step changes one thing: a random control word, a random set of modem input levels, a status read, or the enable inputs. The serial inputs get fresh values at every step. After each step the whole output set is compared with a bench model. Control words with and without the loopback bit show whether the status levels come from the pins or from the control bits, and whether the pins are held inactive. Directed cases drive the ring input high-to-low and then low-to-high, which shows the trailing-edge rule apart from plain change detection. A read is also timed to fall on the very cycle a new change is caught, which shows whether setting a flag wins over clearing it.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
   // modem status line indices (status levels and change flags share them)
   localparam int MDM_LINES = 4;
   localparam int LN_CTS    = 0;
   localparam int LN_DSR    = 1;
   localparam int LN_RI     = 2;
   localparam int LN_DCD    = 3;
   localparam int CTL_W     = 5;

   // control register, bit 0 in the lowest field
   typedef struct packed {
      logic loop;   // bit 4
      logic out2;   // bit 3: user pin and interrupt output enable
      logic out1;   // bit 2
      logic rts;    // bit 1
      logic dtr;    // bit 0
   } mdm_ctl_t;

   function automatic logic [MDM_LINES-1:0] loop_levels(input mdm_ctl_t c);
      logic [MDM_LINES-1:0] v;
      v[LN_CTS] = c.rts;
      v[LN_DSR] = c.dtr;
      v[LN_RI]  = c.out1;
      v[LN_DCD] = c.out2;
      return v;
   endfunction
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
   parameter int W = 4,
   parameter int STAGES = 2,
   parameter logic [W-1:0] INIT = '1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $fatal(1, "mdm_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) chain_q <= {STAGES{INIT}};
      else     chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta #(
   parameter int LINES = 4,
   parameter int TRAIL_IDX = 2,
   parameter bit TRAIL_ONLY = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [LINES-1:0] level,
   input  logic             clr,
   output logic [LINES-1:0] flags
);
   generate
      if (TRAIL_IDX >= LINES) begin : g_bad_idx
         $fatal(1, "mdm_delta: TRAIL_IDX out of range");
      end
   endgenerate

   logic [LINES-1:0] prev_q;
   logic [LINES-1:0] flag_q;
   logic [LINES-1:0] event_c;

   for (genvar i = 0; i < LINES; i++) begin : g_line
      if (TRAIL_ONLY && i == TRAIL_IDX) begin : g_trail
         // asserted level dropping == active-low pin rising
         assign event_c[i] = prev_q[i] & ~level[i];
      end else begin : g_any
         assign event_c[i] = prev_q[i] ^ level[i];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= '0;
         flag_q <= '0;
      end else begin
         prev_q <= level;
         flag_q <= event_c | (clr ? '0 : flag_q);
      end
   end

   assign flags = flag_q;
endmodule

// File: rtl/modem_ctl_top.sv
module modem_ctl_top #(
   parameter int DATA_W = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit RI_TRAIL_ONLY = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mcr_we,
   input  logic [DATA_W-1:0] mcr_wdata,
   input  logic              msr_rd,
   output logic [7:0]        msr_q,
   input  logic              msi_en,
   input  logic              auto_rts_en,
   input  logic              cts_n,
   input  logic              dsr_n,
   input  logic              ri_n,
   input  logic              dcd_n,
   output logic              rts_n,
   output logic              dtr_n,
   output logic              usr_n,
   output logic              irq_oe,
   output logic              msi_req,
   output logic              flow_hold,
   input  logic              tx_ser,
   output logic              txd,
   input  logic              rxd,
   output logic              rx_ser
);
   import mdm_pkg::*;

   generate
      if (DATA_W < CTL_W) begin : g_bad_w
         $fatal(1, "modem_ctl_top: DATA_W too narrow for control register");
      end
      if (DATA_W > CTL_W) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^mcr_wdata[DATA_W-1:CTL_W];
      end
   endgenerate

   mdm_ctl_t ctl_q;
   logic     loop_on;

   always_ff @(posedge clk) begin
      if (rst)         ctl_q <= '0;
      else if (mcr_we) ctl_q <= mdm_ctl_t'(mcr_wdata[CTL_W-1:0]);
   end

   assign loop_on = ctl_q.loop;

   // pin side: active-low inputs synchronised, idle value all ones
   logic [MDM_LINES-1:0] pins_n;
   logic [MDM_LINES-1:0] pins_sync_n;
   logic [MDM_LINES-1:0] level_c;
   logic [MDM_LINES-1:0] flags;

   always_comb begin
      pins_n          = '1;
      pins_n[LN_CTS]  = cts_n;
      pins_n[LN_DSR]  = dsr_n;
      pins_n[LN_RI]   = ri_n;
      pins_n[LN_DCD]  = dcd_n;
   end

   mdm_sync #(
      .W(MDM_LINES),
      .STAGES(SYNC_STAGES),
      .INIT({MDM_LINES{1'b1}})
   ) u_sync (
      .clk(clk),
      .rst(rst),
      .d(pins_n),
      .q(pins_sync_n)
   );

   assign level_c = loop_on ? loop_levels(ctl_q) : ~pins_sync_n;

   mdm_delta #(
      .LINES(MDM_LINES),
      .TRAIL_IDX(LN_RI),
      .TRAIL_ONLY(RI_TRAIL_ONLY)
   ) u_delta (
      .clk(clk),
      .rst(rst),
      .level(level_c),
      .clr(msr_rd),
      .flags(flags)
   );

   assign msr_q     = {level_c, flags};
   assign msi_req   = msi_en & (|flags);

   // control pins: held inactive while looped back
   assign rts_n     = loop_on | ~ctl_q.rts;
   assign dtr_n     = loop_on | ~ctl_q.dtr;
   assign usr_n     = loop_on | ~ctl_q.out2;
   assign irq_oe    = ctl_q.out2;
   assign flow_hold = auto_rts_en & ~ctl_q.rts;

   // serial path
   assign txd    = (rst | loop_on) ? 1'b1 : tx_ser;
   assign rx_ser = rst ? 1'b1 : (loop_on ? tx_ser : rxd);
endmodule

// File: rtl/modem_ctl_chk.sv
module modem_ctl_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              mcr_we,
   input logic [DATA_W-1:0] mcr_wdata,
   input logic [7:0]        msr_q,
   input logic              msi_en,
   input logic              auto_rts_en,
   input logic              rts_n,
   input logic              dtr_n,
   input logic              usr_n,
   input logic              irq_oe,
   input logic              msi_req,
   input logic              flow_hold,
   input logic              tx_ser,
   input logic              txd,
   input logic              rx_ser,
   input logic              loop_on
);
   assert_user_pin_R1: assert property (@(posedge clk) disable iff (rst)
      mcr_we |=> (irq_oe == $past(mcr_wdata[3])) &&
                 (usr_n == ($past(mcr_wdata[4]) | ~$past(mcr_wdata[3]))));

   assert_reset_serial_R2: assert property (@(posedge clk)
      rst |-> (txd && rx_ser));

   assert_reset_pins_R2: assert property (@(posedge clk)
      rst |=> (rts_n && dtr_n && usr_n && !irq_oe && msr_q[3:0] == 4'h0));

   assert_rts_pin_R3: assert property (@(posedge clk) disable iff (rst)
      mcr_we |=> rts_n == ($past(mcr_wdata[4]) | ~$past(mcr_wdata[1])));

   assert_flow_gate_R4: assert property (@(posedge clk) disable iff (rst)
      !auto_rts_en |-> !flow_hold);

   assert_cts_change_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(msr_q[0]) |-> ($past(msr_q[4], 2) != $past(msr_q[4])));

   assert_ri_trailing_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(msr_q[2]) |-> ($past(msr_q[6], 2) && !$past(msr_q[6])));

   assert_msi_gate_R8: assert property (@(posedge clk) disable iff (rst)
      msi_req |-> (msi_en && msr_q[3:0] != 4'h0));

   assert_loop_rx_R9: assert property (@(posedge clk) disable iff (rst)
      loop_on |-> (txd && rx_ser == tx_ser));

   assert_loop_pins_R10: assert property (@(posedge clk) disable iff (rst)
      loop_on |-> (rts_n && dtr_n && usr_n));
endmodule

bind modem_ctl_top modem_ctl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk),
   .rst(rst),
   .mcr_we(mcr_we),
   .mcr_wdata(mcr_wdata),
   .msr_q(msr_q),
   .msi_en(msi_en),
   .auto_rts_en(auto_rts_en),
   .rts_n(rts_n),
   .dtr_n(dtr_n),
   .usr_n(usr_n),
   .irq_oe(irq_oe),
   .msi_req(msi_req),
   .flow_hold(flow_hold),
   .tx_ser(tx_ser),
   .txd(txd),
   .rx_ser(rx_ser),
   .loop_on(loop_on)
);

// File: tb/modem_ctl_tb.sv
module modem_ctl_top_tb_top;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic mcr_we = 1'b0;
   logic [7:0] mcr_wdata = 8'h00;
   logic msr_rd = 1'b0;
   logic msi_en = 1'b0;
   logic auto_rts_en = 1'b0;
   logic [3:0] pn = 4'hF;     // {dcd_n, ri_n, dsr_n, cts_n}
   logic tx_ser = 1'b0;
   logic rxd = 1'b0;
   logic [7:0] msr_q;
   logic rts_n, dtr_n, usr_n, irq_oe, msi_req, flow_hold, txd, rx_ser;

   always #4 clk = ~clk;   // 125 MHz

   modem_ctl_top #(.DATA_W(8), .SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst(rst), .mcr_we(mcr_we), .mcr_wdata(mcr_wdata),
      .msr_rd(msr_rd), .msr_q(msr_q), .msi_en(msi_en),
      .auto_rts_en(auto_rts_en), .cts_n(pn[0]), .dsr_n(pn[1]),
      .ri_n(pn[2]), .dcd_n(pn[3]), .rts_n(rts_n), .dtr_n(dtr_n),
      .usr_n(usr_n), .irq_oe(irq_oe), .msi_req(msi_req),
      .flow_hold(flow_hold), .tx_ser(tx_ser), .txd(txd), .rxd(rxd),
      .rx_ser(rx_ser)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // bench model
   logic [4:0] m_ctl = 5'h00;
   logic [3:0] m_prev = 4'h0;
   logic [3:0] m_flag = 4'h0;

   function automatic logic [3:0] f_level(input logic [4:0] c, input logic [3:0] p);
      return c[4] ? {c[3], c[2], c[0], c[1]} : ~p;
   endfunction

   function automatic logic [3:0] f_event(input logic [3:0] old_l, input logic [3:0] new_l);
      logic [3:0] e;
      e = old_l ^ new_l;
      e[2] = old_l[2] & ~new_l[2];
      return e;
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_step();
      logic [3:0] nl;
      nl = f_level(m_ctl, pn);
      m_flag = m_flag | f_event(m_prev, nl);
      m_prev = nl;
   endtask

   task automatic check_all();
      chk("R5 R6 R10 status", msr_q, {m_prev, m_flag});
      chk("R3 R10 rts_n", {7'd0, rts_n}, {7'd0, m_ctl[4] | ~m_ctl[1]});
      chk("R3 R10 dtr_n", {7'd0, dtr_n}, {7'd0, m_ctl[4] | ~m_ctl[0]});
      chk("R1 usr_n", {7'd0, usr_n}, {7'd0, m_ctl[4] | ~m_ctl[3]});
      chk("R1 irq_oe", {7'd0, irq_oe}, {7'd0, m_ctl[3]});
      chk("R4 flow_hold", {7'd0, flow_hold}, {7'd0, auto_rts_en & ~m_ctl[1]});
      chk("R8 msi_req", {7'd0, msi_req}, {7'd0, msi_en & (|m_flag)});
      chk("R9 txd", {7'd0, txd}, {7'd0, m_ctl[4] | tx_ser});
      chk("R9 rx_ser", {7'd0, rx_ser}, {7'd0, m_ctl[4] ? tx_ser : rxd});
   endtask

   task automatic settle();
      repeat (SYNC + 2) @(negedge clk);
      model_step();
      check_all();
   endtask

   task automatic write_ctl(input logic [7:0] v);
      mcr_wdata = v;
      mcr_we = 1'b1;
      @(negedge clk);
      mcr_we = 1'b0;
      m_ctl = v[4:0];
      settle();
   endtask

   task automatic read_status();
      chk("R7 read value", msr_q, {m_prev, m_flag});
      msr_rd = 1'b1;
      @(negedge clk);
      msr_rd = 1'b0;
      m_flag = 4'h0;
      settle();
   endtask

   task automatic set_pins(input logic [3:0] v);
      pn = v;
      settle();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1A2B3C4D));
      // R2: during reset
      repeat (3) @(negedge clk);
      chk("R2 txd in reset", {7'd0, txd}, 8'd1);
      chk("R2 rx_ser in reset", {7'd0, rx_ser}, 8'd1);
      rst = 1'b0;
      @(negedge clk);
      chk("R2 pins after reset", {4'd0, rts_n, dtr_n, usr_n, irq_oe}, 8'h0E);
      chk("R2 flags after reset", {4'd0, msr_q[3:0]}, 8'h00);
      settle();

      // R1 R3: control pins
      write_ctl(8'h08);
      write_ctl(8'h03);
      write_ctl(8'h00);
      // R4: flow gate only with auto enable
      auto_rts_en = 1'b1;
      settle();
      write_ctl(8'h02);
      auto_rts_en = 1'b0;
      settle();

      // R6: ring falling leaves flag clear, rising sets it
      msi_en = 1'b1;
      set_pins(4'b1011);
      chk("R6 no flag on ring assert", {7'd0, msr_q[2]}, 8'd0);
      set_pins(4'b1111);
      chk("R6 flag on ring release", {7'd0, msr_q[2]}, 8'd1);
      read_status();
      // R5: other lines flag on both directions
      set_pins(4'b0110);
      read_status();
      set_pins(4'b1111);
      read_status();

      // R7: read coinciding with a newly detected change
      pn = 4'b1110;
      repeat (SYNC) @(negedge clk);
      msr_rd = 1'b1;
      @(negedge clk);
      msr_rd = 1'b0;
      m_flag = 4'h0;
      settle();
      chk("R7 set wins over clear", {4'd0, msr_q[3:0]}, 8'h01);
      read_status();

      // R9 R10: loopback directed
      rxd = 1'b1; tx_ser = 1'b0;
      write_ctl(8'h1F);
      pn = 4'h0;
      settle();
      write_ctl(8'h10);
      chk("R10 ring flag via loop", {7'd0, msr_q[2]}, 8'd1);
      write_ctl(8'h00);
      read_status();

      // random mix
      for (int it = 0; it < 400; it++) begin
         int act;
         act = $urandom_range(0, 3);
         tx_ser = 1'($urandom);
         rxd = 1'($urandom);
         case (act)
            0: write_ctl(8'($urandom));
            1: set_pins(4'($urandom));
            2: read_status();
            default: begin
               msi_en = 1'($urandom);
               auto_rts_en = 1'($urandom);
               settle();
            end
         endcase
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule